// File: doc/BRIEF.md
# Strict SPECIAL-Class Decode and Retire Unit

This unit sits at the end of a simplified single-issue 32-bit MIPS-style core. It accepts one fetched instruction word together with its PC over a valid/ready stream. It classifies the instruction against a deliberately narrow table of legal encodings, applies the architectural effect of that instruction to its own 32-entry register file and HI/LO pair, and reports the retirement. The table is narrow on purpose. A core that grows one accepted encoding at a time must never let a neighbouring, unallocated function code slip through as a silent no-op.

System calls do not vector anywhere. A built-in emulation checks the call number held in r3 against a parameter list of supported numbers. A supported call writes a success value of zero into r2, retires, and updates an observer record with the call number, the argument registers r4..r7 and a running count. An unsupported call halts the unit. An illegal encoding under strict mode traps. Both stop conditions are sticky until reset and keep the location that caused them.

Stream rules: a word is transferred on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high from reset until a trap or halt, and then stays low until reset. A source must hold its word while `in_ready` is low. The result of a transfer is visible on the outputs one cycle later.

Top module: `strict_decode_retire`

## Requirements
- R1: A SPECIAL word (primary opcode 0, bits 31:26) with function field (bits 5:0) 0x0F is a memory barrier. It retires with no change to any register, HI or LO, and its next PC is PC+4.
- R2: Every accepted transfer that is not trapped or halted produces a `retire_pulse` of exactly one cycle in the cycle after the transfer. In that cycle `retire_pc` holds the transferred PC and `retire_next_pc` holds the next PC.
- R3: With `strict_en` high, an unallocated SPECIAL function code (for example word 0x0000000E) does not retire. It sets `trap_flag` and captures the PC in `trap_pc` and the raw word in `trap_instr`.
- R4: With `strict_en` low, an unallocated SPECIAL function code or an unknown primary opcode retires as a no-op with next PC equal to PC+4.
- R5: The SPECIAL ALU functions write rd (bits 15:11). They are SLL 0x00, SRL 0x02, SRA 0x03 (shift of rt by bits 10:6), ADDU 0x21, SUBU 0x23, AND 0x24, OR 0x25, XOR 0x26, NOR 0x27, SLT 0x2A (signed) and SLTU 0x2B, with rs in bits 25:21 and rt in bits 20:16.
- R6: MFHI 0x10 and MFLO 0x12 copy HI or LO into rd. MTHI 0x11 and MTLO 0x13 copy rs into HI or LO.
- R7: JR 0x08 gives a next PC equal to rs. JALR 0x09 gives a next PC equal to the old rs and writes PC+4 into rd.
- R8: SYSCALL 0x0C with r3 in the supported list writes 0 to r2 and retires with next PC equal to PC+4. It loads the observer with the r3 value and r4..r7, and raises `obs_count` by one.
- R9: SYSCALL with r3 outside the supported list does not retire. It sets `halt_flag` and reports the PC and the r3 value of that call.
- R10: After a trap or halt, `in_ready` stays low, nothing retires, and the trap/halt flags and captured values stay unchanged until reset.
- R11: Register r0 always reads 0, whatever instruction targets it.
- R12: The primary opcodes ADDIU 0x09 (rt = rs + sign-extended imm), ORI 0x0D (rt = rs | zero-extended imm) and LUI 0x0F (rt = imm << 16) are accepted. Any other non-zero primary opcode traps when `strict_en` is high.
- R13: After reset, all registers, HI, LO and the observer are zero, no flag or pulse is raised, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_en | input | 1 | Trap on unallocated encodings when high |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Unit can take a word |
| in_pc | input | 32 | PC of the offered word |
| in_instr | input | 32 | Offered instruction word |
| retire_pulse | output | 1 | One-cycle retirement strobe |
| retire_pc | output | 32 | PC of the retired word |
| retire_next_pc | output | 32 | Next PC after the retired word |
| trap_flag | output | 1 | Sticky illegal-encoding trap |
| trap_pc | output | 32 | PC of the trapping word |
| trap_instr | output | 32 | Raw trapping word |
| halt_flag | output | 1 | Sticky unsupported-call halt |
| halt_pc | output | 32 | PC of the unsupported call |
| halt_callnum | output | 32 | r3 value of the unsupported call |
| obs_callnum | output | 32 | Last emulated call number |
| obs_arg0 | output | 32 | r4 at last emulated call |
| obs_arg1 | output | 32 | r5 at last emulated call |
| obs_arg2 | output | 32 | r6 at last emulated call |
| obs_arg3 | output | 32 | r7 at last emulated call |
| obs_count | output | CNT_W | Emulated calls since reset |
| hi_value | output | 32 | HI register |
| lo_value | output | 32 | LO register |
| dbg_addr | input | 5 | Register view index |
| dbg_data | output | 32 | Register view data |

## Verification
The bench aims at the neighbours of the barrier code. Word 0x0000000E must trap under strict mode and retire under lax mode; a decode that was too wide would retire it silently, and one that was too narrow would trap the barrier itself. It drives system calls with both listed and unlisted numbers in r3. A wrong list compare would halt on a good call or return success on a bad one. JALR with rd equal to rs would expose a target taken from the new value instead of the old. Words offered after a trap would expose a stop condition that is not sticky, because the captured PC would move or a retire pulse would leak out. Writes aimed at r0 would expose a zero register that can be corrupted.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;

  localparam logic [5:0] OP_SPECIAL = 6'h00;
  localparam logic [5:0] OP_ADDIU   = 6'h09;
  localparam logic [5:0] OP_ORI     = 6'h0D;
  localparam logic [5:0] OP_LUI     = 6'h0F;

  localparam logic [5:0] FN_SLL   = 6'h00;
  localparam logic [5:0] FN_SRL   = 6'h02;
  localparam logic [5:0] FN_SRA   = 6'h03;
  localparam logic [5:0] FN_JR    = 6'h08;
  localparam logic [5:0] FN_JALR  = 6'h09;
  localparam logic [5:0] FN_SCALL = 6'h0C;
  localparam logic [5:0] FN_FENCE = 6'h0F;
  localparam logic [5:0] FN_MFHI  = 6'h10;
  localparam logic [5:0] FN_MTHI  = 6'h11;
  localparam logic [5:0] FN_MFLO  = 6'h12;
  localparam logic [5:0] FN_MTLO  = 6'h13;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;
  localparam logic [5:0] FN_AND   = 6'h24;
  localparam logic [5:0] FN_OR    = 6'h25;
  localparam logic [5:0] FN_XOR   = 6'h26;
  localparam logic [5:0] FN_NOR   = 6'h27;
  localparam logic [5:0] FN_SLT   = 6'h2A;
  localparam logic [5:0] FN_SLTU  = 6'h2B;

  typedef enum logic [3:0] {
    K_NOP, K_FENCE, K_ALU, K_IMM, K_MFHL, K_MTHL, K_JR, K_JALR, K_SCALL, K_ILLEGAL
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [5:0]  op;
    logic [5:0]  fn;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [4:0]  rd;
    logic [4:0]  shamt;
    logic [15:0] imm;
  } dec_t;
endpackage

// File: rtl/sdr_decode.sv
module sdr_decode
  import sdr_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  input  logic            strict_en,
  output dec_t            dec
);
  kind_e unknown_kind;

  always_comb begin
    unknown_kind = strict_en ? K_ILLEGAL : K_NOP;
    dec.op    = instr[31:26];
    dec.rs    = instr[25:21];
    dec.rt    = instr[20:16];
    dec.rd    = instr[15:11];
    dec.shamt = instr[10:6];
    dec.fn    = instr[5:0];
    dec.imm   = instr[15:0];
    dec.kind  = unknown_kind;
    if (instr[31:26] == OP_SPECIAL) begin
      unique case (instr[5:0])
        FN_SLL, FN_SRL, FN_SRA,
        FN_ADDU, FN_SUBU, FN_AND, FN_OR,
        FN_XOR, FN_NOR, FN_SLT, FN_SLTU: dec.kind = K_ALU;
        FN_JR:                           dec.kind = K_JR;
        FN_JALR:                         dec.kind = K_JALR;
        FN_SCALL:                        dec.kind = K_SCALL;
        FN_FENCE:                        dec.kind = K_FENCE;
        FN_MFHI, FN_MFLO:                dec.kind = K_MFHL;
        FN_MTHI, FN_MTLO:                dec.kind = K_MTHL;
        default:                         dec.kind = unknown_kind;
      endcase
    end else begin
      unique case (instr[31:26])
        OP_ADDIU, OP_ORI, OP_LUI: dec.kind = K_IMM;
        default:                  dec.kind = unknown_kind;
      endcase
    end
  end
endmodule

// File: rtl/sdr_regfile.sv
module sdr_regfile #(
  parameter int NENT = 32,
  parameter int W    = 32,
  parameter int NRD  = 8,
  parameter int AW   = $clog2(NENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [W-1:0]     wdata,
  input  logic [NRD*AW-1:0] raddr,
  output logic [NRD*W-1:0]  rdata
);
  logic [W-1:0] mem [NENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) mem[i] <= '0;
    end else if (we) begin
      for (int i = 1; i < NENT; i++) begin
        if (waddr == AW'(i)) mem[i] <= wdata;
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [AW-1:0] a;
    assign a = raddr[r*AW +: AW];
    assign rdata[r*W +: W] = (a == '0) ? '0 : mem[a];
  end
endmodule

// File: rtl/sdr_callmatch.sv
module sdr_callmatch #(
  parameter int NUM_CALLS = 4,
  parameter logic [NUM_CALLS*32-1:0] CALL_LIST = {32'h7A, 32'h78, 32'h16, 32'h12}
) (
  input  logic [31:0] callnum,
  output logic        hit
);
  logic [NUM_CALLS-1:0] match;

  for (genvar g = 0; g < NUM_CALLS; g++) begin : g_cmp
    assign match[g] = (callnum == CALL_LIST[g*32 +: 32]);
  end

  assign hit = |match;
endmodule

// File: rtl/sdr_exec.sv
module sdr_exec
  import sdr_pkg::*;
(
  input  dec_t            dec,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] hi,
  input  logic [XLEN-1:0] lo,
  output logic [XLEN-1:0] res,
  output logic [4:0]      dest,
  output logic            wen,
  output logic            hi_we,
  output logic            lo_we,
  output logic [XLEN-1:0] next_pc
);
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] alu_res;
  logic [XLEN-1:0] imm_res;

  assign seq_pc = pc + XLEN'(4);

  always_comb begin
    unique case (dec.fn)
      FN_SLL:  alu_res = b << dec.shamt;
      FN_SRL:  alu_res = b >> dec.shamt;
      FN_SRA:  alu_res = XLEN'($signed(b) >>> dec.shamt);
      FN_ADDU: alu_res = a + b;
      FN_SUBU: alu_res = a - b;
      FN_AND:  alu_res = a & b;
      FN_OR:   alu_res = a | b;
      FN_XOR:  alu_res = a ^ b;
      FN_NOR:  alu_res = ~(a | b);
      FN_SLT:  alu_res = XLEN'($signed(a) < $signed(b));
      FN_SLTU: alu_res = XLEN'(a < b);
      default: alu_res = '0;
    endcase
  end

  always_comb begin
    unique case (dec.op)
      OP_ADDIU: imm_res = a + {{(XLEN-16){dec.imm[15]}}, dec.imm};
      OP_ORI:   imm_res = a | {{(XLEN-16){1'b0}}, dec.imm};
      OP_LUI:   imm_res = {dec.imm, {(XLEN-16){1'b0}}};
      default:  imm_res = '0;
    endcase
  end

  always_comb begin
    res     = '0;
    dest    = '0;
    wen     = 1'b0;
    hi_we   = 1'b0;
    lo_we   = 1'b0;
    next_pc = seq_pc;
    unique case (dec.kind)
      K_ALU: begin
        res = alu_res; dest = dec.rd; wen = 1'b1;
      end
      K_IMM: begin
        res = imm_res; dest = dec.rt; wen = 1'b1;
      end
      K_MFHL: begin
        res = (dec.fn == FN_MFHI) ? hi : lo; dest = dec.rd; wen = 1'b1;
      end
      K_MTHL: begin
        hi_we = (dec.fn == FN_MTHI);
        lo_we = (dec.fn == FN_MTLO);
      end
      K_JR: next_pc = a;
      K_JALR: begin
        next_pc = a; res = seq_pc; dest = dec.rd; wen = 1'b1;
      end
      K_SCALL: begin
        res = '0; dest = 5'd2; wen = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/strict_decode_retire.sv
module strict_decode_retire
  import sdr_pkg::*;
#(
  parameter int NUM_CALLS = 4,
  parameter logic [NUM_CALLS*32-1:0] CALL_LIST = {32'h7A, 32'h78, 32'h16, 32'h12},
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strict_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_pc,
  input  logic [31:0]      in_instr,
  output logic             retire_pulse,
  output logic [31:0]      retire_pc,
  output logic [31:0]      retire_next_pc,
  output logic             trap_flag,
  output logic [31:0]      trap_pc,
  output logic [31:0]      trap_instr,
  output logic             halt_flag,
  output logic [31:0]      halt_pc,
  output logic [31:0]      halt_callnum,
  output logic [31:0]      obs_callnum,
  output logic [31:0]      obs_arg0,
  output logic [31:0]      obs_arg1,
  output logic [31:0]      obs_arg2,
  output logic [31:0]      obs_arg3,
  output logic [CNT_W-1:0] obs_count,
  output logic [31:0]      hi_value,
  output logic [31:0]      lo_value,
  input  logic [4:0]       dbg_addr,
  output logic [31:0]      dbg_data
);
  localparam int AW  = $clog2(NREG);
  localparam int NRD = 8;

  dec_t            dec;
  logic [NRD*AW-1:0]   raddr;
  logic [NRD*XLEN-1:0] rdata;
  logic [XLEN-1:0] rs_val, rt_val, r3_val;
  logic [XLEN-1:0] ex_res, ex_next;
  logic [4:0]      ex_dest;
  logic            ex_wen, ex_hi_we, ex_lo_we;
  logic            call_hit;
  logic            fire, is_call, bad_call, illegal, commit;
  logic            stopped;
  logic [XLEN-1:0] hi_q, lo_q;

  sdr_decode u_dec (
    .instr     (in_instr),
    .strict_en (strict_en),
    .dec       (dec)
  );

  assign raddr = {5'd7, 5'd6, 5'd5, 5'd4, 5'd3, dbg_addr, dec.rt, dec.rs};

  sdr_regfile #(.NENT(NREG), .W(XLEN), .NRD(NRD)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit && ex_wen),
    .waddr (ex_dest),
    .wdata (ex_res),
    .raddr (raddr),
    .rdata (rdata)
  );

  assign rs_val   = rdata[0*XLEN +: XLEN];
  assign rt_val   = rdata[1*XLEN +: XLEN];
  assign dbg_data = rdata[2*XLEN +: XLEN];
  assign r3_val   = rdata[3*XLEN +: XLEN];

  sdr_callmatch #(.NUM_CALLS(NUM_CALLS), .CALL_LIST(CALL_LIST)) u_calls (
    .callnum (r3_val),
    .hit     (call_hit)
  );

  sdr_exec u_exec (
    .dec     (dec),
    .a       (rs_val),
    .b       (rt_val),
    .pc      (in_pc),
    .hi      (hi_q),
    .lo      (lo_q),
    .res     (ex_res),
    .dest    (ex_dest),
    .wen     (ex_wen),
    .hi_we   (ex_hi_we),
    .lo_we   (ex_lo_we),
    .next_pc (ex_next)
  );

  assign stopped  = trap_flag || halt_flag;
  assign in_ready = !stopped;
  assign fire     = in_valid && in_ready;
  assign is_call  = (dec.kind == K_SCALL);
  assign bad_call = is_call && !call_hit;
  assign illegal  = (dec.kind == K_ILLEGAL);
  assign commit   = fire && !illegal && !bad_call;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      retire_pulse   <= 1'b0;
      retire_pc      <= '0;
      retire_next_pc <= '0;
    end else begin
      retire_pulse <= commit;
      if (commit) begin
        retire_pc      <= in_pc;
        retire_next_pc <= ex_next;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_flag  <= 1'b0;
      trap_pc    <= '0;
      trap_instr <= '0;
      halt_flag    <= 1'b0;
      halt_pc      <= '0;
      halt_callnum <= '0;
    end else if (fire) begin
      if (illegal) begin
        trap_flag  <= 1'b1;
        trap_pc    <= in_pc;
        trap_instr <= in_instr;
      end
      if (bad_call) begin
        halt_flag    <= 1'b1;
        halt_pc      <= in_pc;
        halt_callnum <= r3_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obs_callnum <= '0;
      obs_arg0    <= '0;
      obs_arg1    <= '0;
      obs_arg2    <= '0;
      obs_arg3    <= '0;
      obs_count   <= '0;
    end else if (commit && is_call) begin
      obs_callnum <= r3_val;
      obs_arg0    <= rdata[4*XLEN +: XLEN];
      obs_arg1    <= rdata[5*XLEN +: XLEN];
      obs_arg2    <= rdata[6*XLEN +: XLEN];
      obs_arg3    <= rdata[7*XLEN +: XLEN];
      obs_count   <= obs_count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (commit) begin
      if (ex_hi_we) hi_q <= rs_val;
      if (ex_lo_we) lo_q <= rs_val;
    end
  end

  assign hi_value = hi_q;
  assign lo_value = lo_q;
endmodule

// File: rtl/sdr_checker.sv
module sdr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             retire_pulse,
  input logic             trap_flag,
  input logic [31:0]      trap_pc,
  input logic             halt_flag,
  input logic [31:0]      halt_pc,
  input logic [CNT_W-1:0] obs_count,
  input logic [4:0]       dbg_addr,
  input logic [31:0]      dbg_data
);
  assert_retire_needs_transfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    retire_pulse |-> $past(in_valid && in_ready));

  assert_trap_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trap_flag |=> trap_flag);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_flag |=> halt_flag);

  assert_no_retire_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_flag || halt_flag) |-> !retire_pulse);

  assert_trap_pc_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_flag && $past(trap_flag)) |-> $stable(trap_pc));

  assert_halt_pc_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_flag && $past(halt_flag)) |-> $stable(halt_pc));

  assert_count_single_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_count == $past(obs_count)) || (obs_count == $past(obs_count) + CNT_W'(1)));

  assert_zero_reg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_addr == 5'd0) |-> (dbg_data == 32'd0));
endmodule

bind strict_decode_retire sdr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .retire_pulse (retire_pulse),
  .trap_flag    (trap_flag),
  .trap_pc      (trap_pc),
  .halt_flag    (halt_flag),
  .halt_pc      (halt_pc),
  .obs_count    (obs_count),
  .dbg_addr     (dbg_addr),
  .dbg_data     (dbg_data)
);

// File: tb/sim_strict_decode_retire.sv
`timescale 1ns/1ps
module sim_strict_decode_retire;
  localparam int CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, strict_en = 1'b1, in_valid = 1'b0;
  logic [31:0] in_pc = '0, in_instr = '0;
  logic [4:0] dbg_addr = '0;
  logic in_ready, retire_pulse, trap_flag, halt_flag;
  logic [31:0] retire_pc, retire_next_pc, trap_pc, trap_instr, halt_pc, halt_callnum;
  logic [31:0] obs_callnum, obs_arg0, obs_arg1, obs_arg2, obs_arg3;
  logic [31:0] hi_value, lo_value, dbg_data;
  logic [CNT_W-1:0] obs_count;

  strict_decode_retire #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .strict_en(strict_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_instr(in_instr), .retire_pulse(retire_pulse), .retire_pc(retire_pc),
    .retire_next_pc(retire_next_pc), .trap_flag(trap_flag), .trap_pc(trap_pc),
    .trap_instr(trap_instr), .halt_flag(halt_flag), .halt_pc(halt_pc),
    .halt_callnum(halt_callnum), .obs_callnum(obs_callnum), .obs_arg0(obs_arg0),
    .obs_arg1(obs_arg1), .obs_arg2(obs_arg2), .obs_arg3(obs_arg3), .obs_count(obs_count),
    .hi_value(hi_value), .lo_value(lo_value), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  always #4 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m [32];
  logic [31:0] mhi, mlo, mo_num, mo_a0, mo_a1, mo_a2, mo_a3;
  logic [31:0] mtrap_pc, mtrap_instr, mhalt_pc, mhalt_num;
  int mcount;
  bit mtrap, mhalt;
  logic [31:0] calls [4] = '{32'h12, 32'h16, 32'h78, 32'h7A};
  logic [5:0] alu_fns [11] = '{6'h00, 6'h02, 6'h03, 6'h21, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit listed(input logic [31:0] x);
    foreach (calls[i]) if (calls[i] == x) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [31:0] alu_ref(input logic [5:0] fn, input logic [31:0] a, b, input logic [4:0] sh);
    case (fn)
      6'h00: return b << sh;
      6'h02: return b >> sh;
      6'h03: return $signed(b) >>> sh;
      6'h21: return a + b;
      6'h23: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      6'h26: return a ^ b;
      6'h27: return ~(a | b);
      6'h2A: return {31'd0, $signed(a) < $signed(b)};
      default: return {31'd0, a < b};
    endcase
  endfunction

  function automatic void wr(input logic [4:0] idx, input logic [31:0] v);
    if (idx != 0) m[idx] = v;
  endfunction

  task automatic model_reset();
    foreach (m[i]) m[i] = '0;
    mhi = '0; mlo = '0; mcount = 0; mtrap = 0; mhalt = 0;
    mo_num = '0; mo_a0 = '0; mo_a1 = '0; mo_a2 = '0; mo_a3 = '0;
    mtrap_pc = '0; mtrap_instr = '0; mhalt_pc = '0; mhalt_num = '0;
  endtask

  task automatic do_reset(input bit strict);
    @(negedge clk);
    rst_n = 1'b0; strict_en = strict; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic issue(input logic [31:0] pc, input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_pc = pc; in_instr = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic step(input logic [31:0] pc, input logic [31:0] w, input string tag,
                      output logic [31:0] nxt);
    bit er = 0;
    logic [31:0] en = pc + 4;
    logic [5:0] op = w[31:26], fn = w[5:0];
    logic [4:0] rs = w[25:21], rt = w[20:16], rd = w[15:11];
    logic [31:0] a = m[w[25:21]], b = m[w[20:16]];
    logic [31:0] sx = {{16{w[15]}}, w[15:0]};
    logic [4:0] probe;
    if (!mtrap && !mhalt) begin
      if (op == 6'h00) begin
        case (fn)
          6'h00, 6'h02, 6'h03, 6'h21, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A, 6'h2B: begin
            er = 1; wr(rd, alu_ref(fn, a, b, w[10:6]));
          end
          6'h08: begin er = 1; en = a; end
          6'h09: begin er = 1; en = a; wr(rd, pc + 4); end
          6'h0C: begin
            if (listed(m[3])) begin
              er = 1; mcount++; mo_num = m[3];
              mo_a0 = m[4]; mo_a1 = m[5]; mo_a2 = m[6]; mo_a3 = m[7];
              wr(5'd2, 32'd0);
            end else begin
              mhalt = 1; mhalt_pc = pc; mhalt_num = m[3];
            end
          end
          6'h0F: er = 1;
          6'h10: begin er = 1; wr(rd, mhi); end
          6'h12: begin er = 1; wr(rd, mlo); end
          6'h11: begin er = 1; mhi = a; end
          6'h13: begin er = 1; mlo = a; end
          default: if (strict_en) begin mtrap = 1; mtrap_pc = pc; mtrap_instr = w; end
                   else er = 1;
        endcase
      end else begin
        case (op)
          6'h09: begin er = 1; wr(rt, a + sx); end
          6'h0D: begin er = 1; wr(rt, a | {16'd0, w[15:0]}); end
          6'h0F: begin er = 1; wr(rt, {w[15:0], 16'd0}); end
          default: if (strict_en) begin mtrap = 1; mtrap_pc = pc; mtrap_instr = w; end
                   else er = 1;
        endcase
      end
    end
    issue(pc, w);
    chk({tag, " retire"}, {31'd0, retire_pulse}, {31'd0, er});
    if (er) begin
      chk({tag, " retire_pc"}, retire_pc, pc);
      chk({tag, " next_pc"}, retire_next_pc, en);
    end
    chk({tag, " trap R3"}, {31'd0, trap_flag}, {31'd0, mtrap});
    chk({tag, " halt R9"}, {31'd0, halt_flag}, {31'd0, mhalt});
    if (mtrap) begin
      chk({tag, " trap_pc R3"}, trap_pc, mtrap_pc);
      chk({tag, " trap_instr R3"}, trap_instr, mtrap_instr);
    end
    if (mhalt) begin
      chk({tag, " halt_pc R9"}, halt_pc, mhalt_pc);
      chk({tag, " halt_num R9"}, halt_callnum, mhalt_num);
    end
    chk({tag, " hi R6"}, hi_value, mhi);
    chk({tag, " lo R6"}, lo_value, mlo);
    chk({tag, " obs_count R8"}, 32'(obs_count), 32'(mcount));
    chk({tag, " obs_num R8"}, obs_callnum, mo_num);
    chk({tag, " obs_a0 R8"}, obs_arg0, mo_a0);
    chk({tag, " obs_a3 R8"}, obs_arg3, mo_a3);
    probe = (op == 6'h00) ? rd : rt;
    dbg_addr = probe; #1;
    chk({tag, " dest reg"}, dbg_data, m[probe]);
    dbg_addr = 5'(($urandom % 32)); #1;
    chk({tag, " any reg"}, dbg_data, m[dbg_addr]);
    nxt = er ? en : pc;
  endtask

  function automatic logic [31:0] rand_word();
    logic [4:0] rs = 5'($urandom), rt = 5'($urandom), rd = 5'($urandom);
    int k = int'($urandom % 8);
    case (k)
      0, 7: return {6'h00, rs, rt, rd, 5'($urandom), alu_fns[$urandom % 11]};
      1: begin
        logic [5:0] ops [3] = '{6'h09, 6'h0D, 6'h0F};
        return {ops[$urandom % 3], rs, rt, 16'($urandom)};
      end
      2: return {6'h00, 10'd0, rd, 5'd0, ($urandom % 2) ? 6'h10 : 6'h12};
      3: return {6'h00, rs, 15'd0, ($urandom % 2) ? 6'h11 : 6'h13};
      4: return 32'h0000000F;
      5: return {6'h00, rs, 15'd0, 6'h08};
      default: return {6'h00, rs, 5'd0, rd, 5'd0, 6'h09};
    endcase
  endfunction

  bit finished = 0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog R2 actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc, nx;
    void'($urandom(32'h5EED1234));
    do_reset(1'b1);
    // R13 reset state
    chk("R13 retire", {31'd0, retire_pulse}, 32'd0);
    chk("R13 trap", {31'd0, trap_flag}, 32'd0);
    chk("R13 halt", {31'd0, halt_flag}, 32'd0);
    chk("R13 ready", {31'd0, in_ready}, 32'd1);
    chk("R13 count", 32'(obs_count), 32'd0);
    chk("R13 hi", hi_value, 32'd0);
    dbg_addr = 5'd9; #1; chk("R13 reg", dbg_data, 32'd0);

    pc = 32'h0010_0000;
    step(pc, 32'h3402_BEEF, "R12 ori", nx); pc = nx;         // r2 = 0xBEEF
    step(pc, 32'h3C08_1234, "R12 lui", nx); pc = nx;         // r8 = 0x12340000
    step(pc, 32'h0100_0011, "R6 mthi", nx); pc = nx;
    step(pc, 32'h0040_0013, "R6 mtlo", nx); pc = nx;
    step(pc, 32'h0000_000F, "R1 barrier", nx); pc = nx;
    dbg_addr = 5'd2; #1; chk("R1 r2 intact", dbg_data, 32'h0000BEEF);
    chk("R1 hi intact", hi_value, 32'h12340000);
    step(pc, 32'h3400_1234, "R11 ori r0", nx); pc = nx;
    step(pc, 32'h2400_FFFF, "R11 addiu r0", nx); pc = nx;
    dbg_addr = 5'd0; #1; chk("R11 r0 zero", dbg_data, 32'd0);
    step(pc, 32'h3403_007A, "R8 set r3", nx); pc = nx;
    step(pc, 32'h3C04_8000, "R8 set a0", nx); pc = nx;
    step(pc, 32'h0000_000C, "R8 syscall", nx); pc = nx;
    dbg_addr = 5'd2; #1; chk("R8 r2 zero", dbg_data, 32'd0);
    chk("R8 num", obs_callnum, 32'h7A);
    chk("R8 arg0", obs_arg0, 32'h80000000);
    step(pc, 32'h0108_4821, "R5 addu", nx); pc = nx;         // r9 = r8 + r8
    step(pc, 32'h0100_4809, "R7 jalr rd!=rs", nx); pc = nx;
    step(pc, 32'h3410_0040, "R7 set r16", nx); pc = nx;
    step(pc, 32'h0200_8009, "R7 jalr rd==rs", nx); pc = nx;  // jalr r16,r16
    chk("R7 old target", retire_next_pc, 32'h40);

    for (int i = 0; i < 600; i++) begin
      if (($urandom % 10) == 0) begin
        step(pc, {6'h0D, 5'd0, 5'd3, 16'(calls[$urandom % 4])}, "R8 rnd r3", nx); pc = nx;
        step(pc, 32'h0000_000C, "R8 rnd syscall", nx); pc = nx;
      end else begin
        step(pc, rand_word(), "R2 R5 R6 R7 R12 random", nx); pc = nx;
      end
    end
    for (int r = 0; r < 32; r++) begin
      dbg_addr = 5'(r); #1; chk("R5 final reg", dbg_data, m[r]);
    end

    // R3 strict neighbour trap, then R10 stickiness
    step(32'h0011_2990, 32'h0000_000E, "R3 neighbour 0x0E", nx);
    chk("R3 ready low", {31'd0, in_ready}, 32'd0);
    step(32'h0011_2994, 32'h3405_0001, "R10 after trap", nx);
    step(32'h0011_2998, 32'h0000_000F, "R10 barrier after trap", nx);
    chk("R10 trap_pc held", trap_pc, 32'h0011_2990);

    // R12 unknown primary opcode under strict
    do_reset(1'b1);
    step(32'h200, 32'h8C01_0000, "R12 unknown op trap", nx);

    // R4 lax mode
    do_reset(1'b0);
    step(32'h300, 32'h0000_000E, "R4 lax neighbour", nx);
    step(32'h304, 32'h8C01_0000, "R4 lax unknown op", nx);
    chk("R4 no trap", {31'd0, trap_flag}, 32'd0);

    // R9 unsupported call halts
    do_reset(1'b1);
    step(32'h400, 32'h3402_0077, "R9 set r2", nx);
    step(32'h404, 32'h3403_0055, "R9 set r3", nx);
    step(32'h408, 32'h0000_000C, "R9 bad syscall", nx);
    dbg_addr = 5'd2; #1; chk("R9 r2 untouched", dbg_data, 32'h77);
    step(32'h40C, 32'h0000_000C, "R10 after halt", nx);
    chk("R10 halt_pc held", halt_pc, 32'h408);
    chk("R9 halt num", halt_callnum, 32'h55);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule